// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synchronous static RAM with registered inputs and a registered output stage. Every control, address and write-data input is captured on the rising clock edge. A read issued on one edge presents its word after the following edge, so read data lags the command by two edges. A built-in two-bit burst counter steps the low two address bits through four accesses. The stepping order is linear or interleaved, and is chosen by a level input that is sampled when the burst starts.

Writes can target individual bytes under a byte-write master enable, or all bytes at once through a global write enable. Three chip enables of mixed polarity must all be active for a command to select the device, which allows depth expansion. A deselect removes the output drive after a single clock. The output enable gates the drive without waiting for a clock. A sleep input blocks new commands, floats the outputs and abandons any open burst. Sleep keeps the stored data. The data bus is split into input data, output data and a drive-enable flag that an external tristate buffer would use.

Top module: `pipe_burst_sram`

## Requirements
- R1: A selected read strobe captured at edge k drives `dout_en_o` high with the addressed word on `dout_o` after edge k+1, while `oe_n_i` is low and sleep was low at edge k+1.
- R2: With `linear_i` = 1 at the strobe, each advance steps the low two address bits as (start + n) mod 4, where n is the advance count. The upper address bits are held.
- R3: With `linear_i` = 0 at the strobe, the low two address bits on advance n are start XOR (n mod 4).
- R4: After four accesses the burst wraps: a fifth access addresses the starting word again.
- R5: With `gwr_n_i` low, all bytes of the word are written, whatever `bwr_master_n_i` and `bwr_n_i` hold.
- R6: With `gwr_n_i` high and `bwr_master_n_i` low, byte i (`din_i[8i+7:8i]`) is written exactly when `bwr_n_i[i]` is low. With both high, or with no byte selected, the access is a read.
- R7: A strobe selects the device only when `ce_a_n_i` = 0, `ce_b_i` = 1 and `ce_c_n_i` = 0. Otherwise the strobe deselects: nothing is written and no read is issued.
- R8: Single-cycle deselect: after a deselect captured at edge k, the previous access still drives after edge k, and `dout_en_o` is low after edge k+1.
- R9: `oe_n_i` high forces `dout_en_o` low at once, with no clock edge needed. Returning it low restores the drive at once.
- R10: At an edge with `sleep_i` high, the command is ignored, `dout_en_o` goes low and the open burst is dropped. An advance after waking does nothing. Memory contents are kept.
- R11: A cycle with neither strobe nor advance repeats a previous read, so the same word stays driven. It does not repeat a previous write, and after a write nothing is driven.
- R12: While `rst` is high the output is not driven and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on rising edge |
| rst | input | 1 | Synchronous active-high reset of control state |
| addr_i | input | AW | Word address captured on a strobe |
| din_i | input | DW | Write data, captured with the command |
| dout_o | output | DW | Registered read data |
| dout_en_o | output | 1 | Drive enable for the external data buffer |
| strobe_n_i | input | 1 | Active-low address strobe: start an access or deselect |
| adv_n_i | input | 1 | Active-low burst advance |
| ce_a_n_i | input | 1 | Chip enable, active low |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_c_n_i | input | 1 | Chip enable, active low |
| gwr_n_i | input | 1 | Global write, all bytes, active low |
| bwr_master_n_i | input | 1 | Byte-write master enable, active low |
| bwr_n_i | input | DW/BW | Per-byte write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep_i | input | 1 | Sleep: block commands and float outputs |

## Verification
A wrong burst offset or a stale base register shows up as a wrong word on the bus two edges after the faulty advance. A corrupted byte mask shows up only on the next read of that word. A stuck access-valid bit leaves `dout_en_o` high after a deselect or a sleep edge. The reference model exposes that one cycle later than the single-cycle rule allows. A burst that survives sleep gets through only when an advance arrives after waking, so the bench issues exactly that advance.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    // Burst stepping order, chosen at the strobe
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    // Per-cycle command after decoding the control inputs
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_START = 2'd1,
        CMD_NEXT  = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

    localparam int unsigned OFS_W = 2;

    // Low address bits for a given step of a burst
    function automatic logic [OFS_W-1:0] burst_offset(
        burst_order_e     ord,
        logic [OFS_W-1:0] first,
        logic [OFS_W-1:0] step
    );
        if (ord == ORD_LINEAR) begin
            return first + step;
        end
        return first ^ step;
    endfunction

endpackage

// File: rtl/pbs_cmd_decode.sv
module pbs_cmd_decode
    import pbs_pkg::*;
#(
    parameter int unsigned NB = 4
) (
    input  logic          strobe_n,
    input  logic          adv_n,
    input  logic          ce_a_n,
    input  logic          ce_b,
    input  logic          ce_c_n,
    input  logic          gwr_n,
    input  logic          bwr_master_n,
    input  logic [NB-1:0] bwr_n,
    input  logic          sleep,
    input  logic          burst_live,
    output cmd_e          cmd,
    output logic [NB-1:0] wmask
);

    logic selected;

    always_comb begin
        selected = !ce_a_n && ce_b && !ce_c_n;
        if (sleep) begin
            cmd = CMD_HOLD;
        end else if (!strobe_n) begin
            cmd = selected ? CMD_START : CMD_DESEL;
        end else if (!adv_n && burst_live) begin
            cmd = CMD_NEXT;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // Global write outranks the byte lanes
    always_comb begin
        if (!gwr_n) begin
            wmask = '1;
        end else if (!bwr_master_n) begin
            wmask = ~bwr_n;
        end else begin
            wmask = '0;
        end
    end

endmodule

// File: rtl/pbs_burst_ctr.sv
module pbs_burst_ctr
    import pbs_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic          sleep,
    input  logic [AW-1:0] addr_in,
    input  logic          linear,
    output logic          burst_live,
    output logic [AW-1:0] acc_addr
);

    logic [AW-1:0]    base_q;
    logic [OFS_W-1:0] step_q;
    logic [OFS_W-1:0] step_nx;
    burst_order_e     ord_q;
    logic             live_q;

    assign step_nx    = step_q + OFS_W'(1);
    assign burst_live = live_q;

    always_comb begin
        if (cmd == CMD_START) begin
            acc_addr = addr_in;
        end else begin
            acc_addr = {base_q[AW-1:OFS_W], burst_offset(ord_q, base_q[OFS_W-1:0], step_nx)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            step_q <= '0;
            base_q <= '0;
            ord_q  <= ORD_INTERLEAVE;
        end else if (sleep) begin
            live_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_START: begin
                    live_q <= 1'b1;
                    step_q <= '0;
                    base_q <= addr_in;
                    ord_q  <= linear ? ORD_LINEAR : ORD_INTERLEAVE;
                end
                CMD_NEXT:  step_q <= step_nx;
                CMD_DESEL: live_q <= 1'b0;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/pbs_core.sv
module pbs_core
    import pbs_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic          sleep,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW/BW-1:0] wmask,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          out_valid
);

    localparam int unsigned NB    = DW / BW;
    localparam int unsigned DEPTH = 1 << AW;

    // Access stage: the registered command
    logic          acc_v, acc_w;
    logic [AW-1:0] acc_a;
    logic [NB-1:0] acc_m;
    logic [DW-1:0] acc_d;
    logic          out_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_v <= 1'b0;
            acc_w <= 1'b0;
            out_v <= 1'b0;
            acc_a <= '0;
            acc_m <= '0;
            acc_d <= '0;
        end else begin
            out_v <= !sleep && acc_v && !acc_w;
            if (sleep) begin
                acc_v <= 1'b0;
                acc_w <= 1'b0;
            end else begin
                unique case (cmd)
                    CMD_START, CMD_NEXT: begin
                        acc_v <= 1'b1;
                        acc_w <= |wmask;
                        acc_a <= acc_addr;
                        acc_m <= wmask;
                        acc_d <= din;
                    end
                    CMD_DESEL: begin
                        acc_v <= 1'b0;
                        acc_w <= 1'b0;
                    end
                    default: begin
                        // suspend: a read repeats, a write retires
                        if (acc_w) begin
                            acc_v <= 1'b0;
                            acc_w <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    // One storage array and output register per byte lane
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];
        logic [BW-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (acc_v && acc_w && acc_m[b]) begin
                lane_mem[acc_a] <= acc_d[b*BW +: BW];
            end
        end

        always_ff @(posedge clk) begin
            if (acc_v && !acc_w) begin
                lane_q <= lane_mem[acc_a];
            end
        end

        assign dout[b*BW +: BW] = lane_q;
    end

    assign out_valid = out_v;

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       din_i,
    output logic [DW-1:0]       dout_o,
    output logic                dout_en_o,
    input  logic                strobe_n_i,
    input  logic                adv_n_i,
    input  logic                ce_a_n_i,
    input  logic                ce_b_i,
    input  logic                ce_c_n_i,
    input  logic                gwr_n_i,
    input  logic                bwr_master_n_i,
    input  logic [DW/BW-1:0]    bwr_n_i,
    input  logic                oe_n_i,
    input  logic                linear_i,
    input  logic                sleep_i
);

    localparam int unsigned NB = DW / BW;

    cmd_e          cmd;
    logic [NB-1:0] wmask;
    logic          burst_live;
    logic [AW-1:0] acc_addr;
    logic          out_valid;

    pbs_cmd_decode #(.NB(NB)) u_dec (
        .strobe_n     (strobe_n_i),
        .adv_n        (adv_n_i),
        .ce_a_n       (ce_a_n_i),
        .ce_b         (ce_b_i),
        .ce_c_n       (ce_c_n_i),
        .gwr_n        (gwr_n_i),
        .bwr_master_n (bwr_master_n_i),
        .bwr_n        (bwr_n_i),
        .sleep        (sleep_i),
        .burst_live   (burst_live),
        .cmd          (cmd),
        .wmask        (wmask)
    );

    pbs_burst_ctr #(.AW(AW)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .sleep      (sleep_i),
        .addr_in    (addr_i),
        .linear     (linear_i),
        .burst_live (burst_live),
        .acc_addr   (acc_addr)
    );

    pbs_core #(.AW(AW), .DW(DW), .BW(BW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .sleep     (sleep_i),
        .acc_addr  (acc_addr),
        .wmask     (wmask),
        .din       (din_i),
        .dout      (dout_o),
        .out_valid (out_valid)
    );

    // Output enable acts without a clock
    assign dout_en_o = out_valid && !oe_n_i;

endmodule

// File: rtl/pbs_chk.sv
module pbs_chk (
    input logic clk,
    input logic rst,
    input logic strobe_n,
    input logic ce_a_n,
    input logic ce_b,
    input logic ce_c_n,
    input logic gwr_n,
    input logic bwr_master_n,
    input logic oe_n,
    input logic sleep,
    input logic dout_en
);

    logic sel, rd_start;
    assign sel      = !ce_a_n && ce_b && !ce_c_n;
    assign rd_start = !strobe_n && sel && !sleep && gwr_n && bwr_master_n;

    // R12
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !dout_en);

    // R9
    oe_float_chk: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dout_en);

    // R10
    sleep_float_chk: assert property (@(posedge clk) disable iff (rst) sleep |=> !dout_en);

    // R8
    desel_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !sel && !sleep) |=> ##1 !dout_en);

    // R1
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst) && $past(rd_start, 2) && !$past(sleep) && !oe_n)
        |-> dout_en);

endmodule

bind pipe_burst_sram pbs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .strobe_n     (strobe_n_i),
    .ce_a_n       (ce_a_n_i),
    .ce_b         (ce_b_i),
    .ce_c_n       (ce_c_n_i),
    .gwr_n        (gwr_n_i),
    .bwr_master_n (bwr_master_n_i),
    .oe_n         (oe_n_i),
    .sleep        (sleep_i),
    .dout_en      (dout_en_o)
);

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int BW = 8;
    localparam int NB = DW / BW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en;
    logic strobe_n = 1'b1, adv_n = 1'b1;
    logic ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
    logic gwr_n = 1'b1, bwr_master_n = 1'b1;
    logic [NB-1:0] bwr_n = '1;
    logic oe_n = 1'b0, linear = 1'b1, sleep = 1'b0;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;
    string phase = "R12 reset";

    always #5 clk = ~clk;

    pipe_burst_sram #(.AW(AW), .DW(DW), .BW(BW)) dut (
        .clk(clk), .rst(rst), .addr_i(addr), .din_i(din), .dout_o(dout),
        .dout_en_o(dout_en), .strobe_n_i(strobe_n), .adv_n_i(adv_n),
        .ce_a_n_i(ce_a_n), .ce_b_i(ce_b), .ce_c_n_i(ce_c_n), .gwr_n_i(gwr_n),
        .bwr_master_n_i(bwr_master_n), .bwr_n_i(bwr_n), .oe_n_i(oe_n),
        .linear_i(linear), .sleep_i(sleep)
    );

    function automatic logic [DW-1:0] pat(int a);
        return {8'(a), 8'(a * 7 + 1), 8'(255 - a), 8'(a ^ 8'h3C)};
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_known [DEPTH];
    bit m_acc_v, m_acc_w, m_out_v, m_out_k, m_burst, m_lin;
    int m_acc_a, m_base, m_first, m_steps;
    logic [NB-1:0] m_acc_m;
    logic [DW-1:0] m_acc_d, m_out_d;

    function automatic int m_target(int steps);
        int lo;
        lo = m_lin ? (m_first + steps) % 4 : (m_first ^ (steps % 4));
        return m_base * 4 + lo;
    endfunction

    function automatic logic [NB-1:0] m_mask();
        if (!gwr_n) return '1;
        if (!bwr_master_n) return ~bwr_n;
        return '0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc_v = 0; m_acc_w = 0; m_out_v = 0; m_burst = 0;
        end else begin
            bit rd;
            rd = m_acc_v && !m_acc_w;
            if (rd) begin
                m_out_d = m_mem[m_acc_a];
                m_out_k = m_known[m_acc_a];
            end
            if (m_acc_v && m_acc_w) begin
                for (int b = 0; b < NB; b++)
                    if (m_acc_m[b]) m_mem[m_acc_a][b*BW +: BW] = m_acc_d[b*BW +: BW];
                if (m_acc_m == '1) m_known[m_acc_a] = 1;
            end
            m_out_v = !sleep && rd;
            if (sleep) begin
                m_acc_v = 0; m_acc_w = 0; m_burst = 0;
            end else if (!strobe_n) begin
                if (!ce_a_n && ce_b && !ce_c_n) begin
                    m_burst = 1; m_lin = linear; m_steps = 0;
                    m_base = int'(addr) / 4; m_first = int'(addr) % 4;
                    m_acc_v = 1; m_acc_a = int'(addr); m_acc_m = m_mask();
                    m_acc_w = (m_acc_m != 0); m_acc_d = din;
                end else begin
                    m_burst = 0; m_acc_v = 0; m_acc_w = 0;
                end
            end else if (!adv_n && m_burst) begin
                m_steps++;
                m_acc_v = 1; m_acc_a = m_target(m_steps); m_acc_m = m_mask();
                m_acc_w = (m_acc_m != 0); m_acc_d = din;
            end else if (m_acc_w) begin
                m_acc_v = 0; m_acc_w = 0;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit exp_en;
            exp_en = m_out_v && !oe_n;
            checks++;
            if (dout_en !== exp_en) begin
                fails++;
                $display("FAIL %s: dout_en=%b expected %b at t=%0t", phase, dout_en, exp_en, $time);
            end else if (exp_en && m_out_k && dout !== m_out_d) begin
                fails++;
                $display("FAIL %s: dout=%h expected %h at t=%0t", phase, dout, m_out_d, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        strobe_n = 1; adv_n = 1; gwr_n = 1; bwr_master_n = 1; bwr_n = '1;
        ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    endtask

    task automatic wr1(int a, logic [DW-1:0] d, logic g, logic m, logic [NB-1:0] b);
        strobe_n = 0; addr = AW'(a); din = d; gwr_n = g; bwr_master_n = m; bwr_n = b;
        cyc();
        idle();
    endtask

    task automatic rd1(int a, output logic [DW-1:0] got);
        strobe_n = 0; addr = AW'(a);
        cyc();
        idle();
        cyc();
        got = dout;
        check({phase, " read enable"}, {31'd0, dout_en}, 32'd1);
    endtask

    // Reads a burst with four advances; e0..e3 are the expected addresses
    task automatic rd_burst(int a, logic lin, int e0, int e1, int e2, int e3, string tag);
        logic [DW-1:0] g [5];
        strobe_n = 0; addr = AW'(a); linear = lin;
        cyc();
        strobe_n = 1; adv_n = 0;
        for (int i = 0; i < 4; i++) begin
            cyc();
            g[i] = dout;
            if (i == 3) idle();
        end
        cyc();
        g[4] = dout;
        check({tag, " step0"}, g[0], pat(e0));
        check({tag, " step1"}, g[1], pat(e1));
        check({tag, " step2"}, g[2], pat(e2));
        check({tag, " step3"}, g[3], pat(e3));
        check("R4 wrap to start", g[4], pat(e0));
    endtask

    // ---------------- watchdog ----------------
    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 20000);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [DW-1:0] got;
        logic [DW-1:0] nd;
        for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
        repeat (3) cyc();
        check("R12 no drive in reset", {31'd0, dout_en}, 32'd0);
        rst = 0;
        cyc();
        check("R12 idle after reset", {31'd0, dout_en}, 32'd0);

        // Fill memory with global-write bursts, byte enables deliberately off (R5)
        phase = "R5 fill";
        for (int b = 0; b < DEPTH / 4; b++) begin
            strobe_n = 0; addr = AW'(4 * b); gwr_n = 0; bwr_master_n = b[0]; bwr_n = '1;
            linear = b[1]; din = pat(4 * b);
            cyc();
            strobe_n = 1; adv_n = 0;
            for (int j = 1; j < 4; j++) begin
                din = pat(4 * b + j);
                cyc();
            end
            idle();
        end
        cyc();

        phase = "R1 single read";
        rd1(37, got);
        check("R1 read latency data", got, pat(37));

        phase = "R2 linear";
        rd_burst(6'h16, 1'b1, 6'h16, 6'h17, 6'h14, 6'h15, "R2 linear from 2");
        rd_burst(6'h2B, 1'b1, 6'h2B, 6'h28, 6'h29, 6'h2A, "R2 linear from 3");
        phase = "R3 interleaved";
        rd_burst(6'h15, 1'b0, 6'h15, 6'h14, 6'h17, 6'h16, "R3 interleave from 1");
        rd_burst(6'h33, 1'b0, 6'h33, 6'h32, 6'h31, 6'h30, "R3 interleave from 3");

        phase = "R6 byte write";
        wr1(9, 32'hAABBCCDD, 1'b1, 1'b0, 4'b1010);
        rd1(9, got);
        nd = pat(9);
        check("R6 lanes 0 and 2 written", got, {nd[31:24], 8'hBB, nd[15:8], 8'hDD});
        wr1(9, 32'h0, 1'b1, 1'b1, 4'b0000);
        rd1(9, got);
        check("R6 master off is a read", got, {nd[31:24], 8'hBB, nd[15:8], 8'hDD});

        phase = "R5 global write";
        wr1(11, 32'hCAFEF00D, 1'b0, 1'b1, 4'b1111);
        rd1(11, got);
        check("R5 all bytes written", got, 32'hCAFEF00D);

        phase = "R7 chip enables";
        for (int k = 0; k < 3; k++) begin
            strobe_n = 0; addr = AW'(12); din = 32'hDEADBEEF; gwr_n = 0;
            ce_a_n = (k == 0); ce_b = (k != 1); ce_c_n = (k == 2);
            cyc();
            idle();
            cyc();
            cyc();
            check("R7 deselected read not driven", {31'd0, dout_en}, 32'd0);
        end
        rd1(12, got);
        check("R7 deselected write ignored", got, pat(12));

        phase = "R8 deselect";
        strobe_n = 0; addr = AW'(3);
        cyc();
        ce_b = 0;
        cyc();
        check("R8 still driven one cycle", {31'd0, dout_en}, 32'd1);
        check("R8 data before deselect", dout, pat(3));
        idle();
        cyc();
        check("R8 floated after one more edge", {31'd0, dout_en}, 32'd0);

        phase = "R11 suspend";
        strobe_n = 0; addr = AW'(5);
        cyc();
        idle();
        cyc(); cyc(); cyc();
        check("R11 read repeated", dout, pat(5));
        phase = "R9 output enable";
        oe_n = 1;
        #1 check("R9 async float", {31'd0, dout_en}, 32'd0);
        oe_n = 0;
        #1 check("R9 async restore", {31'd0, dout_en}, 32'd1);
        phase = "R11 suspend";
        wr1(7, 32'h01234567, 1'b0, 1'b1, '1);
        cyc(); cyc();
        check("R11 no drive after write", {31'd0, dout_en}, 32'd0);
        rd1(7, got);
        check("R11 write kept", got, 32'h01234567);

        phase = "R10 sleep";
        strobe_n = 0; addr = AW'(10); linear = 1;
        cyc();
        strobe_n = 1; adv_n = 0;
        cyc();
        sleep = 1; adv_n = 1; strobe_n = 0; addr = AW'(20); gwr_n = 0; din = 32'hFFFFFFFF;
        cyc();
        check("R10 floated on sleep edge", {31'd0, dout_en}, 32'd0);
        cyc(); cyc();
        sleep = 0; idle(); adv_n = 0;
        cyc(); cyc();
        check("R10 burst abandoned", {31'd0, dout_en}, 32'd0);
        idle();
        rd1(20, got);
        check("R10 command ignored in sleep", got, pat(20));
        rd1(11, got);
        check("R10 contents kept", got, 32'hCAFEF00D);

        cyc(); cyc();
        summary();
    end

endmodule